// File: doc/BRIEF.md
# Output Slice Enable and Static Level Controller

This block produces the pull-up and pull-down control bits for a bank of identical, parallel output slices. Each slice holds one leg per binary drive weight. The output impedance is set by the number of slices that are switched on. A slice that is switched off is tri-stated by gating its data: both its pull-up and its pull-down stay off in every leg, and no series device is added. The equalization weights arrive as one drive bit per weight. The same bits go to every enabled slice, so the enable count and the tap weights can each be changed without touching the other.

Among the enabled slices, any slice can be set to a fixed level. It then drives a constant high or a constant low in all of its legs instead of following data. This changes the output swing for margin tests. The number of conducting legs per weight, and so the impedance, does not change. The enable count, the static-slice mask and the static levels are captured together into one active set by an update strobe. New settings therefore switch on a single clock edge, and the bank never passes through a mixed state.

Top module: `slice_bank_ctl`

## Requirements
- R1: While reset is asserted and on the first edge after it, all pull-up and pull-down outputs are 0. The active set after reset is an enable count of 18 with no static slices.
- R2: Slice s is enabled exactly when s is less than the active enable count. A requested count above NUM_SLICES (22) is saturated to 22.
- R3: A disabled slice has pull-up 0 and pull-down 0 on every weight.
- R4: An enabled slice without a static request drives pu = drive_i[w] and pd = ~drive_i[w] on weight w. The output bit index is s*NUM_WEIGHTS + w.
- R5: An enabled slice whose mask bit is 1 drives pu = level bit and pd = ~level bit on every weight, whatever the drive bits are. A level bit of 1 means constant high.
- R6: A static request on a disabled slice is ignored, and the slice stays tri-stated.
- R7: No leg ever has pull-up and pull-down on at the same time.
- R8: On every cycle, for every weight, the number of slices with a conducting leg equals the active enable count. This holds for any static mask and any drive bits.
- R9: Count, mask and level inputs are captured only on a cycle with update_i high, and all three together. Without the strobe, changes on these inputs have no effect. The outputs show a newly captured set from the second edge after the strobe edge onward.
- R10: The drive bits pass through one register stage. The outputs show the drive_i value sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| update_i | input | 1 | Strobe that captures count, mask and level |
| en_count_i | input | 5 | Requested number of enabled slices |
| static_mask_i | input | 22 | 1 = slice held at a fixed level |
| static_level_i | input | 22 | Fixed level per slice, 1 = high |
| drive_i | input | 5 | Per-weight data bits from the serializer |
| pu_o | output | 110 | Pull-up enables, bit s*5+w |
| pd_o | output | 110 | Pull-down enables, bit s*5+w |

## Verification
A wrong active count, or a mask bit that leaks into a disabled slice, changes how many legs conduct in a weight column. This appears on pu_o/pd_o one edge after the active set changes. Both the per-column count and the full-vector comparison against an independent model catch it. A capture that ignores the strobe, or captures only part of the set, shows up two edges after the input change as a vector that mixes old and new settings. A drive path with the wrong latency or polarity shows up one edge after drive_i changes, on every dynamic slice.

// File: rtl/slice_ctl_pkg.sv
package slice_ctl_pkg;

  // Clamp a requested slice count to the number of slices present.
  function automatic int unsigned clamp_count(input int unsigned req,
                                              input int unsigned limit);
    return (req > limit) ? limit : req;
  endfunction

  // Leg state for one slice and one weight: {pull_up, pull_down}.
  function automatic logic [1:0] leg_state(input logic enabled,
                                           input logic is_static,
                                           input logic level,
                                           input logic data);
    logic drive_high;
    drive_high = is_static ? level : data;
    if (!enabled) return 2'b00;
    return {drive_high, ~drive_high};
  endfunction

endpackage

// File: rtl/slice_cfg_shadow.sv
module slice_cfg_shadow #(
  parameter int NUM_SLICES = 22,
  parameter int DEFAULT_EN = 18,
  localparam int CW = $clog2(NUM_SLICES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  update_i,
  input  logic [CW-1:0]         count_i,
  input  logic [NUM_SLICES-1:0] mask_i,
  input  logic [NUM_SLICES-1:0] level_i,
  output logic [CW-1:0]         count_o,
  output logic [NUM_SLICES-1:0] enable_o,
  output logic [NUM_SLICES-1:0] mask_o,
  output logic [NUM_SLICES-1:0] level_o
);
  import slice_ctl_pkg::*;

  logic [CW-1:0] count_sat;
  assign count_sat = CW'(clamp_count(int'(count_i), NUM_SLICES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= CW'(DEFAULT_EN);
      mask_o  <= '0;
      level_o <= '0;
    end else if (update_i) begin
      count_o <= count_sat;
      mask_o  <= mask_i;
      level_o <= level_i;
    end
  end

  // Thermometer enable derived from the active count.
  always_comb begin
    for (int s = 0; s < NUM_SLICES; s++)
      enable_o[s] = (s < int'(count_o));
  end

  // Active set only moves on a strobe (R9).
  assert_hold_without_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !update_i |=> ($stable(count_o) && $stable(mask_o) && $stable(level_o)));

  // Saturation keeps the active count within the bank (R2).
  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    update_i |=> (int'(count_o) <= NUM_SLICES));

endmodule

// File: rtl/slice_leg_decode.sv
module slice_leg_decode #(
  parameter int NUM_WEIGHTS = 5
) (
  input  logic                   enabled_i,
  input  logic                   static_i,
  input  logic                   level_i,
  input  logic [NUM_WEIGHTS-1:0] drive_i,
  output logic [NUM_WEIGHTS-1:0] pu_o,
  output logic [NUM_WEIGHTS-1:0] pd_o
);
  import slice_ctl_pkg::*;

  for (genvar w = 0; w < NUM_WEIGHTS; w++) begin : g_leg
    logic [1:0] st;
    assign st    = leg_state(enabled_i, static_i, level_i, drive_i[w]);
    assign pu_o[w] = st[1];
    assign pd_o[w] = st[0];
  end

endmodule

// File: rtl/slice_bank_ctl.sv
module slice_bank_ctl #(
  parameter int NUM_SLICES  = 22,
  parameter int NUM_WEIGHTS = 5,
  parameter int DEFAULT_EN  = 18,
  localparam int CW = $clog2(NUM_SLICES + 1),
  localparam int NB = NUM_SLICES * NUM_WEIGHTS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   update_i,
  input  logic [CW-1:0]          en_count_i,
  input  logic [NUM_SLICES-1:0]  static_mask_i,
  input  logic [NUM_SLICES-1:0]  static_level_i,
  input  logic [NUM_WEIGHTS-1:0] drive_i,
  output logic [NB-1:0]          pu_o,
  output logic [NB-1:0]          pd_o
);

  logic [CW-1:0]         act_count;
  logic [NUM_SLICES-1:0] act_enable;
  logic [NUM_SLICES-1:0] act_mask;
  logic [NUM_SLICES-1:0] act_level;
  logic [NB-1:0]         pu_next;
  logic [NB-1:0]         pd_next;
  logic                  out_valid;

  slice_cfg_shadow #(
    .NUM_SLICES(NUM_SLICES),
    .DEFAULT_EN(DEFAULT_EN)
  ) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .update_i (update_i),
    .count_i  (en_count_i),
    .mask_i   (static_mask_i),
    .level_i  (static_level_i),
    .count_o  (act_count),
    .enable_o (act_enable),
    .mask_o   (act_mask),
    .level_o  (act_level)
  );

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    slice_leg_decode #(.NUM_WEIGHTS(NUM_WEIGHTS)) u_dec (
      .enabled_i (act_enable[s]),
      .static_i  (act_mask[s]),
      .level_i   (act_level[s]),
      .drive_i   (drive_i),
      .pu_o      (pu_next[s*NUM_WEIGHTS +: NUM_WEIGHTS]),
      .pd_o      (pd_next[s*NUM_WEIGHTS +: NUM_WEIGHTS])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pu_o      <= '0;
      pd_o      <= '0;
      out_valid <= 1'b0;
    end else begin
      pu_o      <= pu_next;
      pd_o      <= pd_next;
      out_valid <= 1'b1;
    end
  end

  // Weight columns of the registered outputs, brought out for the checks.
  logic [NUM_SLICES-1:0] pu_col [NUM_WEIGHTS];
  logic [NUM_SLICES-1:0] pd_col [NUM_WEIGHTS];
  for (genvar w = 0; w < NUM_WEIGHTS; w++) begin : g_col
    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_bit
      assign pu_col[w][s] = pu_o[s*NUM_WEIGHTS + w];
      assign pd_col[w][s] = pd_o[s*NUM_WEIGHTS + w];
    end

    // Conducting legs per weight track the active count of the prior cycle (R8).
    assert_conducting_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(pu_col[w] | pd_col[w]) == int'($past(act_count))));
  end

  // Never both branches on in one leg (R7).
  assert_no_crowbar_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_o & pd_o) == '0);

  // Outputs cleared straight out of reset (R1).
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (pu_o == '0 && pd_o == '0));

endmodule

// File: tb/test_slice_bank_ctl.sv
module test_slice_bank_ctl;
  localparam int NS = 22;
  localparam int NW = 5;
  localparam int NB = NS * NW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          update_i = 1'b0;
  logic [4:0]    en_count_i = '0;
  logic [NS-1:0] static_mask_i = '0;
  logic [NS-1:0] static_level_i = '0;
  logic [NW-1:0] drive_i = '0;
  logic [NB-1:0] pu_o, pd_o;

  int tests = 0;
  int fails = 0;

  // Model of the active set, kept by the bench.
  int            m_cnt = 18;
  logic [NS-1:0] m_mask = '0;
  logic [NS-1:0] m_lvl = '0;
  logic [NW-1:0] m_drv = '0;

  always #5 clk = ~clk;

  slice_bank_ctl i_slice_bank_ctl (
    .clk(clk), .rst_n(rst_n), .update_i(update_i), .en_count_i(en_count_i),
    .static_mask_i(static_mask_i), .static_level_i(static_level_i),
    .drive_i(drive_i), .pu_o(pu_o), .pd_o(pd_o)
  );

  typedef struct packed {
    logic [4:0]    cnt;
    logic [NS-1:0] mask;
    logic [NS-1:0] lvl;
    logic [NW-1:0] drv;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{5'd18, 22'h0,      22'h0,      5'b10111},
    '{5'd22, 22'h0,      22'h0,      5'b01000},
    '{5'd10, 22'h0000F0, 22'h000030, 5'b11111},
    '{5'd4,  22'h3F0000, 22'h3F0000, 5'b00000},
    '{5'd0,  22'h3FFFFF, 22'h155555, 5'b10101},
    '{5'd31, 22'h200001, 22'h000001, 5'b01010},
    '{5'd1,  22'h000001, 22'h000000, 5'b11111},
    '{5'd21, 22'h0AAAAA, 22'h3FFFFF, 5'b00110}
  };

  // Bench's own view of each leg.
  task automatic expect_vec(output logic [NB-1:0] epu, output logic [NB-1:0] epd);
    for (int s = 0; s < NS; s++) begin
      for (int w = 0; w < NW; w++) begin
        bit on, hi;
        on = (s < m_cnt);
        hi = m_mask[s] ? m_lvl[s] : m_drv[w];
        epu[s*NW+w] = on && hi;
        epd[s*NW+w] = on && !hi;
      end
    end
  endtask

  task automatic check_all(input string req);
    logic [NB-1:0] epu, epd;
    expect_vec(epu, epd);
    tests++;
    if (pu_o !== epu || pd_o !== epd) begin
      fails++;
      $display("FAIL %s: pu=%h pd=%h expected pu=%h pd=%h", req, pu_o, pd_o, epu, epd);
    end
    tests++;
    if ((pu_o & pd_o) != '0) begin
      fails++;
      $display("FAIL R7: overlap=%h expected 0", pu_o & pd_o);
    end
    for (int w = 0; w < NW; w++) begin
      int n = 0;
      for (int s = 0; s < NS; s++) n += int'(pu_o[s*NW+w] | pd_o[s*NW+w]);
      tests++;
      if (n != m_cnt) begin
        fails++;
        $display("FAIL R8: weight %0d conducting=%0d expected %0d", w, n, m_cnt);
      end
    end
  endtask

  task automatic apply_cfg(input vec_t v);
    @(negedge clk);
    en_count_i = v.cnt; static_mask_i = v.mask; static_level_i = v.lvl;
    drive_i = v.drv; update_i = 1'b1;
    @(negedge clk);
    update_i = 1'b0;
    m_cnt = (int'(v.cnt) > NS) ? NS : int'(v.cnt);
    m_mask = v.mask; m_lvl = v.lvl; m_drv = v.drv;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    tests++;
    if (pu_o !== '0 || pd_o !== '0) begin
      fails++;
      $display("FAIL R1: pu=%h pd=%h expected 0", pu_o, pd_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_all("R1 default count 18");

    // Table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      apply_cfg(VECS[i]);
      check_all("R2/R3/R4/R5/R6 table");
    end

    // R2: saturation above the bank size
    apply_cfg('{5'd31, 22'h0, 22'h0, 5'b11001});
    check_all("R2 saturate");

    // R6: static request on disabled slices only
    apply_cfg('{5'd3, 22'h3FFFF8, 22'h3FFFF8, 5'b00000});
    check_all("R6 ignored on disabled");

    // R9: inputs changed without strobe are ignored
    @(negedge clk);
    en_count_i = 5'd20; static_mask_i = 22'h3FFFFF; static_level_i = 22'h3FFFFF;
    repeat (3) @(negedge clk);
    check_all("R9 no strobe");

    // R9: after strobe, set appears on second edge, not first
    apply_cfg('{5'd12, 22'h000002, 22'h000002, 5'b00000});
    check_all("R9 applied together");
    @(negedge clk);
    en_count_i = 5'd7; static_mask_i = 22'h0; update_i = 1'b1;
    @(negedge clk);
    update_i = 1'b0;
    check_all("R9 old set one edge after strobe");
    m_cnt = 7; m_mask = '0;
    @(negedge clk);
    check_all("R9 new set two edges after strobe");

    // R10: drive latency of one edge
    drive_i = 5'b11010;
    check_all("R10 before edge");
    m_drv = 5'b11010;
    @(negedge clk);
    check_all("R10 one edge later");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule